// File: doc/BRIEF.md
# Packed Saturating Add, Subtract and Average Unit

This block performs lane-wise integer arithmetic on a 128-bit vector. The vector is split into lanes of 8, 16, 32 or 64 bits, and a two-bit selector picks the lane size. Each lane combines the matching lanes of two source vectors, `src_s` and `src_t`. The operation is chosen by a 4-bit opcode. The unit covers:

- saturating sums and differences in signed, unsigned and mixed-signedness forms
- sums of magnitudes, both wrapping and clamping
- floor and ceiling averages that cannot overflow
- absolute differences

No carry or borrow ever crosses a lane boundary.

A request is presented with `in_valid`. The packed result appears in `out_data` one clock later, qualified by `out_valid`. The output register holds its value while no request is presented. Reset is synchronous and active high.

Top module: `vsat_alu`

## Requirements
- R1: `lane_sel` picks the lane width: 0 gives 8 bits (16 lanes), 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits (2 lanes). Lane k occupies bits [k*W +: W], and each lane is computed with no carry or borrow from its neighbours.
- R2: Opcode 0 adds both lanes as signed numbers and clamps the sum to the signed maximum or minimum. Opcode 1 adds them as unsigned numbers and clamps to all ones.
- R3: Opcode 2 subtracts `src_t` from `src_s` as signed numbers and clamps to the signed limits. Opcode 3 subtracts them as unsigned numbers and yields zero when the minuend is the smaller.
- R4: Opcode 4 treats the `src_s` lane as unsigned and the `src_t` lane as signed, and computes their difference. The difference is clamped to the range from zero up to all ones.
- R5: Opcode 5 subtracts two unsigned lanes and clamps the true difference to the signed range.
- R6: Opcode 6 adds the magnitudes of both signed lanes and wraps modulo 2^W.
- R7: Opcode 7 adds the magnitudes of both signed lanes and clamps to the signed maximum. This includes the case where either lane holds the most negative value.
- R8: Opcodes 8 and 9 give the floor of the lane average, signed and unsigned respectively. Opcodes 10 and 11 give the ceiling of the average, signed and unsigned. None of them ever overflows.
- R9: Opcode 12 gives the magnitude of the signed difference, modulo 2^W. Opcode 13 gives the larger unsigned lane minus the smaller.
- R10: Opcodes 14 and 15 give an all-zero result.
- R11: `out_valid` is high exactly in the cycle after an accepted request, and `out_data` then carries that request's result. With `in_valid` low, `out_data` keeps its value. Reset clears both `out_valid` and `out_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Operation code |
| lane_sel | input | 2 | Lane width select |
| src_s | input | 128 | First source vector |
| src_t | input | 128 | Second source vector |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 128 | Registered packed result |

## Verification
Clamping toward the upper limit and clamping toward the lower limit can both happen in one result word, in neighbouring lanes. When that happens, a carry-isolation fault would show up as damage to the lane next door. The bench provokes this in two ways: directed vectors built from extreme lane values (zero, one, the signed extremes, all ones), and random vectors whose lanes overflow in mixed directions. Each lane of the result is compared separately against a widened-integer reference model, so a clamp that leaks across a lane boundary is caught as a lane mismatch.

// File: rtl/vsat_pkg.sv
package vsat_pkg;
  localparam int VEC_W   = 128;
  localparam int OP_W    = 4;
  localparam int SEL_W   = 2;
  localparam int N_SIZES = 4;
  localparam int MIN_W   = 8;

  typedef enum logic [OP_W-1:0] {
    OP_ADDS_S  = 4'd0,
    OP_ADDS_U  = 4'd1,
    OP_SUBS_S  = 4'd2,
    OP_SUBS_U  = 4'd3,
    OP_SUB_US  = 4'd4,
    OP_SUB_UUS = 4'd5,
    OP_MAG_ADD = 4'd6,
    OP_MAG_SAT = 4'd7,
    OP_AVG_S   = 4'd8,
    OP_AVG_U   = 4'd9,
    OP_AVGR_S  = 4'd10,
    OP_AVGR_U  = 4'd11,
    OP_DIFF_S  = 4'd12,
    OP_DIFF_U  = 4'd13,
    OP_RSV0    = 4'd14,
    OP_RSV1    = 4'd15
  } vsat_op_e;
endpackage

// File: rtl/vsat_lane.sv
module vsat_lane
  import vsat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  vsat_op_e     op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  localparam int E = W + 2;

  logic signed [E-1:0] sa, sb, ua, ub;
  logic signed [E-1:0] smax, smin, umax;
  logic signed [E-1:0] na, nb, t;
  logic signed [W-1:0] xs, hs;
  logic [W-1:0] xu;

  always_comb begin
    sa   = {{2{a[W-1]}}, a};
    sb   = {{2{b[W-1]}}, b};
    ua   = {2'b00, a};
    ub   = {2'b00, b};
    smax = {3'b000, {(W-1){1'b1}}};
    smin = {3'b111, {(W-1){1'b0}}};
    umax = {2'b00, {W{1'b1}}};
    // negated magnitudes: never overflow for the most negative input
    na   = sa[E-1] ? sa : -sa;
    nb   = sb[E-1] ? sb : -sb;
    xu   = a ^ b;
    xs   = $signed(xu);
    hs   = xs >>> 1;
    t    = '0;
    res  = '0;
    unique case (op)
      OP_ADDS_S, OP_SUBS_S, OP_SUB_UUS: begin
        if (op == OP_ADDS_S)      t = sa + sb;
        else if (op == OP_SUBS_S) t = sa - sb;
        else                      t = ua - ub;
        if (t > smax)      res = smax[W-1:0];
        else if (t < smin) res = smin[W-1:0];
        else               res = t[W-1:0];
      end
      OP_ADDS_U: begin
        t   = ua + ub;
        res = (t > umax) ? umax[W-1:0] : t[W-1:0];
      end
      OP_SUBS_U: begin
        t   = ua - ub;
        res = t[E-1] ? '0 : t[W-1:0];
      end
      OP_SUB_US: begin
        t = ua - sb;
        if (t[E-1])        res = '0;
        else if (t > umax) res = umax[W-1:0];
        else               res = t[W-1:0];
      end
      OP_MAG_ADD: begin
        t   = -(na + nb);
        res = t[W-1:0];
      end
      OP_MAG_SAT: begin
        t = na + nb;
        if (t < -smax) res = smax[W-1:0];
        else begin
          t   = -t;
          res = t[W-1:0];
        end
      end
      OP_AVG_S:  res = (a & b) + hs;
      OP_AVG_U:  res = (a & b) + (xu >> 1);
      OP_AVGR_S: res = (a | b) - hs;
      OP_AVGR_U: res = (a | b) - (xu >> 1);
      OP_DIFF_S: begin
        t   = sa - sb;
        t   = t[E-1] ? -t : t;
        res = t[W-1:0];
      end
      OP_DIFF_U: begin
        t   = (ua >= ub) ? (ua - ub) : (ub - ua);
        res = t[W-1:0];
      end
      default: res = '0;
    endcase
  end

  p_addu_not_below_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_ADDS_U) |-> (res >= a));
  p_magsat_nonneg_r7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MAG_SAT) |-> !res[W-1]);
  p_subu_le_minuend_r3: assert property (@(posedge clk) disable iff (rst)
    (op == OP_SUBS_U) |-> (res <= a));
endmodule

// File: rtl/vsat_bank.sv
module vsat_bank
  import vsat_pkg::*;
#(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  vsat_op_e         op,
  input  logic [VEC_W-1:0] va,
  input  logic [VEC_W-1:0] vb,
  output logic [VEC_W-1:0] vr
);
  localparam int LANES = VEC_W / W;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    vsat_lane #(.W(W)) i_lane (
      .clk (clk),
      .rst (rst),
      .op  (op),
      .a   (va[k*W +: W]),
      .b   (vb[k*W +: W]),
      .res (vr[k*W +: W])
    );
  end
endmodule

// File: rtl/vsat_alu.sv
module vsat_alu
  import vsat_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [OP_W-1:0]    op,
  input  logic [SEL_W-1:0]   lane_sel,
  input  logic [VEC_W-1:0]   src_s,
  input  logic [VEC_W-1:0]   src_t,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_data
);
  vsat_op_e         op_e;
  logic [VEC_W-1:0] bank_res [N_SIZES];
  logic [VEC_W-1:0] sel_res;

  assign op_e = vsat_op_e'(op);

  for (genvar g = 0; g < N_SIZES; g++) begin : g_size
    vsat_bank #(.W(MIN_W << g)) i_bank (
      .clk (clk),
      .rst (rst),
      .op  (op_e),
      .va  (src_s),
      .vb  (src_t),
      .vr  (bank_res[g])
    );
  end

  assign sel_res = bank_res[lane_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= sel_res;
    end
  end

  p_valid_next_r11: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data)));
  p_unused_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op[3:1] == 3'b111) |=> (out_data == '0));
endmodule

// File: tb/test_vsat_alu.sv
`timescale 1ns/1ps
module test_vsat_alu;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [3:0]   op;
  logic [1:0]   lane_sel;
  logic [127:0] src_s, src_t;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vsat_alu i_vsat_alu (
    .clk, .rst, .in_valid, .op, .lane_sel, .src_s, .src_t, .out_valid, .out_data
  );

  function automatic logic [63:0] ref_lane(int o, int w, logic [63:0] a, logic [63:0] b);
    logic signed [69:0] one, umax, smax, smin, ua, ub, sa, sb, t, ma, mb;
    one  = 70'sd1;
    umax = (one <<< w) - one;
    smax = (one <<< (w-1)) - one;
    smin = -(one <<< (w-1));
    ua = {6'b0, a} & umax;
    ub = {6'b0, b} & umax;
    sa = (ua > smax) ? ua - (one <<< w) : ua;
    sb = (ub > smax) ? ub - (one <<< w) : ub;
    ma = (sa < 0) ? -sa : sa;
    mb = (sb < 0) ? -sb : sb;
    case (o)
      0: begin t = sa + sb; t = (t > smax) ? smax : (t < smin) ? smin : t; end
      1: begin t = ua + ub; t = (t > umax) ? umax : t; end
      2: begin t = sa - sb; t = (t > smax) ? smax : (t < smin) ? smin : t; end
      3: begin t = ua - ub; t = (t < 0) ? 0 : t; end
      4: begin t = ua - sb; t = (t < 0) ? 0 : (t > umax) ? umax : t; end
      5: begin t = ua - ub; t = (t > smax) ? smax : (t < smin) ? smin : t; end
      6: t = ma + mb;
      7: begin t = ma + mb; t = (t > smax) ? smax : t; end
      8: t = (sa + sb) >>> 1;
      9: t = (ua + ub) >>> 1;
      10: t = (sa + sb + one) >>> 1;
      11: t = (ua + ub + one) >>> 1;
      12: begin t = sa - sb; t = (t < 0) ? -t : t; end
      13: begin t = ua - ub; t = (t < 0) ? -t : t; end
      default: t = 0;
    endcase
    t = t & umax;
    return t[63:0];
  endfunction

  function automatic logic [127:0] ref_vec(int o, int sz, logic [127:0] a, logic [127:0] b);
    int w = 8 << sz;
    logic [127:0] r = '0;
    logic [63:0] m = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] la, lb, lr;
      la = a[63:0] & m;
      lb = b[63:0] & m;
      la = 64'((a >> (i*w))) & m;
      lb = 64'((b >> (i*w))) & m;
      lr = ref_lane(o, w, la, lb);
      r  = r | ({64'd0, lr} << (i*w));
    end
    return r;
  endfunction

  function automatic string req_of(int o);
    case (o)
      0, 1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      8, 9, 10, 11: return "R8";
      12, 13: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [127:0] pat(int k, int sz);
    int w = 8 << sz;
    logic [63:0] v;
    logic [127:0] r = '0;
    case (k)
      0: v = 64'd0;
      1: v = 64'd1;
      2: v = (64'd1 << (w-1)) - 64'd1;
      3: v = 64'd1 << (w-1);
      default: v = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    endcase
    for (int i = 0; i < 128 / w; i++) r = r | ({64'd0, v} << (i*w));
    return r;
  endfunction

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic run(int o, int sz, logic [127:0] a, logic [127:0] b, string req);
    @(negedge clk);
    in_valid = 1'b1; op = 4'(o); lane_sel = 2'(sz); src_s = a; src_t = b;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) begin
      errors++;
      $display("FAIL R11 out_valid got %b exp 1", out_valid);
    end
    check(req, out_data, ref_vec(o, sz, a, b));
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog got timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'h5A17));
    rst = 1'b1; in_valid = 1'b0; op = '0; lane_sel = '0; src_s = '0; src_t = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== '0) begin
      errors++;
      $display("FAIL R11 reset got %b/%h exp 0/0", out_valid, out_data);
    end
    rst = 1'b0;

    // R1: same operands, different lane widths give width-specific clamps
    run(1, 0, pat(4, 0), pat(1, 0), "R1");
    run(1, 3, pat(4, 0), pat(1, 0), "R1");
    run(0, 1, {64'h7FFF_8000_7FFF_8000, 64'h0001_FFFF_7FFF_8000},
              {64'h0001_FFFF_0001_FFFF, 64'h7FFF_8000_0001_FFFF}, "R1");

    // directed extremes over every opcode and width
    for (int o = 0; o < 16; o++)
      for (int sz = 0; sz < 4; sz++)
        for (int ka = 0; ka < 5; ka++)
          for (int kb = 0; kb < 5; kb++)
            run(o, sz, pat(ka, sz), pat(kb, sz), req_of(o));

    // random stimulus, mixed lane overflow directions
    for (int n = 0; n < 3000; n++) begin
      int o = int'($urandom % 16);
      int sz = int'($urandom % 4);
      run(o, sz, {$urandom, $urandom, $urandom, $urandom},
                 {$urandom, $urandom, $urandom, $urandom}, req_of(o));
    end

    // R11: idle cycle leaves data untouched
    held = out_data;
    @(negedge clk);
    src_s = '1; src_t = '1; op = 4'd1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R11 idle valid got %b exp 0", out_valid);
    end
    check("R11", out_data, held);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule